// File: doc/BRIEF.md
# Quadrature Encoder Timer

The block is a small timer that counts events from two external inputs, A and B. In plain mode it counts up on the selected edge of input A. In quadrature mode it decodes the two phases of an incremental encoder and counts up or down. The selected polarity (rising, falling or both edges) decides which transitions count, so rising-only and falling-only encoder modes each give two counts per encoder cycle, and both-edges mode gives four. Both inputs are resynchronized into the system clock and edge-detected before decoding.

Software drives the block through a register port with a single write strobe and a combinational read port. The mode and polarity can only be changed while the block is disabled. The auto-reload (ceiling) and compare values can only be written while it is enabled. Each accepted write of one of these two values raises a sticky acknowledge flag after a fixed delay, which models the hand-off into a slower counting domain. Counting in continuous mode starts only when a start request arrives after the enable bit is already set. The counter wraps between zero and the auto-reload value in both directions.

Top module: `enc_timer`

## Requirements
- R1: After reset, reads return 0 from CTRL (address 0), CFG (address 1), COUNT (address 4) and STATUS (address 5), and all ones from RELOAD (address 2).
- R2: With CFG bit 0 (quad) clear, the count only increments, once per active edge of input A. CFG bits 2:1 select the active edge: 0 rising, 1 falling, 2 or 3 both. Input B has no effect.
- R3: With quad set and rising polarity, only rising edges count: A rising counts down if B is high and up if B is low, and B rising counts up if A is high and down if A is low. With falling polarity, only falling edges count: A falling counts up if B is high and down if B is low, and B falling counts down if A is high and up if A is low.
- R4: With quad set and both-edges polarity, the rising and falling rules of R3 both apply, so one full encoder cycle moves the count by four.
- R5: A count-up step with the count at or above RELOAD gives a count of 0.
- R6: A count-down step with the count at 0 gives the RELOAD value.
- R7: A CFG write while CTRL bit 0 (enable) is set is ignored.
- R8: Writes to RELOAD or COMPARE (address 3) while enable is clear are discarded and raise no flag.
- R9: An accepted RELOAD write sets STATUS bit 0, and an accepted COMPARE write sets STATUS bit 1. The flag reads as set after the third rising clock edge that follows the write edge, and not before. It stays set.
- R10: Writing 1 to a bit of CLEAR (address 6) clears the matching STATUS bit. Bit 0 clears the RELOAD flag and bit 1 clears the COMPARE flag.
- R11: Setting enable from 0 clears the count. A CTRL write with bit 1 (start) sets running, readable as CTRL bit 1, only if enable was already set before that write. While running is clear the count holds. Clearing enable also clears running.
- R12: A change on an input pin moves the count at the third rising clock edge after the change, and not at the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | WIDTH | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | WIDTH | Register read data, combinational from rdAddr |
| encA | input | 1 | Input A, asynchronous |
| encB | input | 1 | Input B, asynchronous |

## Verification
The bench builds the block with WIDTH set to 8, ACK_DELAY at 3 and SYNC_STAGES at 2. This keeps the all-ones reset value of the reload register small. It also lets a reload of 200 show the down-wrap from zero within a few encoder steps. The default acknowledge delay and synchronizer depth let the bench probe the exact edge at which a flag appears and at which a pin change reaches the count. It also checks one edge earlier in both cases, which would reveal a missing or extra register stage.

// File: rtl/enc_timer_pkg.sv
package enc_timer_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CFG    = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_RELOAD = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CMP    = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_CLEAR  = 3'd6;

  typedef enum logic [1:0] {
    POL_RISE  = 2'd0,
    POL_FALL  = 2'd1,
    POL_BOTH  = 2'd2,
    POL_BOTH2 = 2'd3
  } pol_e;

  // Strobes and settings handed from control to datapath
  typedef struct packed {
    logic clearCount;
    logic countEn;
    logic quadMode;
    pol_e pol;
  } ctl_s;

endpackage

// File: rtl/enc_timer_ack.sv
module enc_timer_ack #(
  parameter int DELAY = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic setReq,
  input  logic clrReq,
  output logic flag
);

  logic [DELAY-1:0] stage;

  generate
    if (DELAY == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= '0;
        else       stage <= setReq;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= '0;
        else       stage <= {stage[DELAY-2:0], setReq};
      end
    end
  endgenerate

  // The delayed request wins over a clear arriving in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flag <= 1'b0;
    else       flag <= (flag & ~clrReq) | stage[DELAY-1];
  end

endmodule

// File: rtl/enc_timer_ctrl.sv
module enc_timer_ctrl
  import enc_timer_pkg::*;
#(
  parameter int WIDTH     = 16,
  parameter int ACK_DELAY = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WIDTH-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WIDTH-1:0]  rdData,
  input  logic [WIDTH-1:0]  count,
  output ctl_s              ctl,
  output logic [WIDTH-1:0]  reloadVal
);

  logic             enable;
  logic             running;
  logic             quadMode;
  pol_e             pol;
  logic [WIDTH-1:0] cmpVal;
  logic             reloadOk;
  logic             cmpOk;

  logic wrCtrl, wrCfg, wrReload, wrCmp, wrClear;
  logic reloadAcc, cmpAcc;

  always_comb begin
    wrCtrl    = wrEn && (wrAddr == ADDR_CTRL);
    wrCfg     = wrEn && (wrAddr == ADDR_CFG);
    wrReload  = wrEn && (wrAddr == ADDR_RELOAD);
    wrCmp     = wrEn && (wrAddr == ADDR_CMP);
    wrClear   = wrEn && (wrAddr == ADDR_CLEAR);
    reloadAcc = wrReload && enable;
    cmpAcc    = wrCmp && enable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable    <= 1'b0;
      running   <= 1'b0;
      quadMode  <= 1'b0;
      pol       <= POL_RISE;
      reloadVal <= '1;
      cmpVal    <= '0;
    end else begin
      if (wrCtrl) begin
        enable  <= wrData[0];
        // start only honoured when enable was set before this write
        running <= wrData[0] & enable & (wrData[1] | running);
      end
      if (wrCfg && !enable) begin
        quadMode <= wrData[0];
        pol      <= pol_e'(wrData[2:1]);
      end
      if (reloadAcc) reloadVal <= wrData;
      if (cmpAcc)    cmpVal    <= wrData;
    end
  end

  always_comb begin
    ctl.clearCount = wrCtrl && wrData[0] && !enable;
    ctl.countEn    = running;
    ctl.quadMode   = quadMode;
    ctl.pol        = pol;
  end

  enc_timer_ack #(.DELAY(ACK_DELAY)) u_ackReload (
    .clk    (clk),
    .rstN   (rstN),
    .setReq (reloadAcc),
    .clrReq (wrClear && wrData[0]),
    .flag   (reloadOk)
  );

  enc_timer_ack #(.DELAY(ACK_DELAY)) u_ackCmp (
    .clk    (clk),
    .rstN   (rstN),
    .setReq (cmpAcc),
    .clrReq (wrClear && wrData[1]),
    .flag   (cmpOk)
  );

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_CTRL:   rdData[1:0] = {running, enable};
      ADDR_CFG:    rdData[2:0] = {pol, quadMode};
      ADDR_RELOAD: rdData      = reloadVal;
      ADDR_CMP:    rdData      = cmpVal;
      ADDR_COUNT:  rdData      = count;
      ADDR_STATUS: rdData[1:0] = {cmpOk, reloadOk};
      default:     rdData      = '0;
    endcase
  end

endmodule

// File: rtl/enc_timer_decode.sv
module enc_timer_decode
  import enc_timer_pkg::*;
(
  input  logic [1:0] rise,
  input  logic [1:0] fall,
  input  logic [1:0] lvl,
  input  logic       quadMode,
  input  pol_e       pol,
  output logic       stepUp,
  output logic       stepDn
);

  // index 0 is input A, index 1 is input B
  logic useRise, useFall;
  logic upA, dnA, upB, dnB;

  always_comb begin
    useRise = (pol != POL_FALL);
    useFall = (pol != POL_RISE);

    upA = (useRise & rise[0] & ~lvl[1]) | (useFall & fall[0] &  lvl[1]);
    dnA = (useRise & rise[0] &  lvl[1]) | (useFall & fall[0] & ~lvl[1]);
    upB = (useRise & rise[1] &  lvl[0]) | (useFall & fall[1] & ~lvl[0]);
    dnB = (useRise & rise[1] & ~lvl[0]) | (useFall & fall[1] &  lvl[0]);

    if (quadMode) begin
      stepUp = (upA | upB) & ~(dnA | dnB);
      stepDn = (dnA | dnB) & ~(upA | upB);
    end else begin
      stepUp = (useRise & rise[0]) | (useFall & fall[0]);
      stepDn = 1'b0;
    end
  end

endmodule

// File: rtl/enc_timer_datapath.sv
module enc_timer_datapath
  import enc_timer_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             encA,
  input  logic             encB,
  input  ctl_s             ctl,
  input  logic [WIDTH-1:0] reloadVal,
  output logic [WIDTH-1:0] count
);

  localparam int NUM_IN = 2;

  logic [NUM_IN-1:0] pins;
  logic [NUM_IN-1:0] syncd;
  logic [NUM_IN-1:0] prev;
  logic [NUM_IN-1:0] rise;
  logic [NUM_IN-1:0] fall;
  logic              stepUp;
  logic              stepDn;

  assign pins = {encB, encA};

  generate
    for (genvar i = 0; i < NUM_IN; i++) begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[SYNC_STAGES-2:0], pins[i]};
      end
      assign syncd[i] = chain[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prev <= '0;
    else       prev <= syncd;
  end

  assign rise = syncd & ~prev;
  assign fall = ~syncd & prev;

  enc_timer_decode u_dec (
    .rise     (rise),
    .fall     (fall),
    .lvl      (syncd),
    .quadMode (ctl.quadMode),
    .pol      (ctl.pol),
    .stepUp   (stepUp),
    .stepDn   (stepDn)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (ctl.clearCount) begin
      count <= '0;
    end else if (ctl.countEn) begin
      if (stepUp)
        count <= (count >= reloadVal) ? '0 : count + WIDTH'(1);
      else if (stepDn)
        count <= (count == '0) ? reloadVal : count - WIDTH'(1);
    end
  end

endmodule

// File: rtl/enc_timer.sv
module enc_timer
  import enc_timer_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int ACK_DELAY   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WIDTH-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WIDTH-1:0]  rdData,
  input  logic              encA,
  input  logic              encB
);

  ctl_s             ctl;
  logic [WIDTH-1:0] reloadVal;
  logic [WIDTH-1:0] count;

  enc_timer_ctrl #(
    .WIDTH     (WIDTH),
    .ACK_DELAY (ACK_DELAY)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .count     (count),
    .ctl       (ctl),
    .reloadVal (reloadVal)
  );

  enc_timer_datapath #(
    .WIDTH       (WIDTH),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .encA      (encA),
    .encB      (encB),
    .ctl       (ctl),
    .reloadVal (reloadVal),
    .count     (count)
  );

endmodule

// File: rtl/enc_timer_checker.sv
module enc_timer_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [2:0]       wrAddr,
  input logic [WIDTH-1:0] wrData,
  input logic             enable,
  input logic             running,
  input logic             quadMode,
  input logic [1:0]       pol,
  input logic [WIDTH-1:0] reloadVal,
  input logic [WIDTH-1:0] count,
  input logic             stepUp,
  input logic             stepDn,
  input logic             reloadOk
);

  AST_RUN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    running |-> enable); // R11

  AST_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enable) |-> count == '0); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(running) && !$rose(enable)) |-> $stable(count)); // R11

  AST_WRAP_UP: assert property (@(posedge clk) disable iff (!rstN)
    (running && stepUp && count >= reloadVal) |=> count == '0); // R5

  AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (running && stepDn && count == '0) |=> count == $past(reloadVal)); // R6

  AST_PLAIN_NO_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (running && !quadMode) |-> !stepDn); // R2

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (enable && wrEn && wrAddr == 3'd1) |=> ($stable(quadMode) && $stable(pol))); // R7

  AST_RELOAD_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && wrEn && wrAddr == 3'd2) |=> $stable(reloadVal)); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reloadOk) |-> $past(wrEn && wrAddr == 3'd6 && wrData[0])); // R10

endmodule

bind enc_timer enc_timer_checker #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .wrData    (wrData),
  .enable    (u_ctrl.enable),
  .running   (u_ctrl.running),
  .quadMode  (u_ctrl.quadMode),
  .pol       (u_ctrl.pol),
  .reloadVal (reloadVal),
  .count     (count),
  .stepUp    (u_dp.stepUp),
  .stepDn    (u_dp.stepDn),
  .reloadOk  (u_ctrl.reloadOk)
);

// File: tb/enc_timer_bench.sv
module enc_timer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [2:0]   wrAddr = '0;
  logic [W-1:0] wrData = '0;
  logic [2:0]   rdAddr = '0;
  logic [W-1:0] rdData;
  logic         encA = 1'b0;
  logic         encB = 1'b0;

  int total = 0;
  int bad = 0;
  int pushed = 0;
  int popped = 0;
  bit finished = 1'b0;

  int    expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  enc_timer #(.WIDTH(W), .ACK_DELAY(3), .SYNC_STAGES(2)) u_enc_timer (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .encA   (encA),
    .encB   (encB)
  );

  // monitor: pops expected items and compares against the read port
  initial begin
    forever begin
      wait (pushed > popped);
      #1;
      total++;
      if (int'(rdData) != expQ[0]) begin
        bad++;
        $display("FAIL %s: actual=%0d expected=%0d", tagQ[0], rdData, expQ[0]);
      end
      void'(expQ.pop_front());
      void'(tagQ.pop_front());
      popped++;
    end
  end

  // driver side of the scoreboard, called just after a falling edge
  task automatic expectNow(input logic [2:0] a, input int e, input string tag);
    rdAddr = a;
    expQ.push_back(e);
    tagQ.push_back(tag);
    pushed++;
    wait (popped == pushed);
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = W'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setAB(input logic a, input logic b);
    @(negedge clk);
    encA = a; encB = b;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulseA();
    setAB(1'b1, encB);
    setAB(1'b0, encB);
  endtask

  task automatic fwdCycle();
    setAB(1, 0); setAB(1, 1); setAB(0, 1); setAB(0, 0);
  endtask

  task automatic revCycle();
    setAB(0, 1); setAB(1, 1); setAB(1, 0); setAB(0, 0);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    expectNow(3'd0, 0, "R1 ctrl reset");
    expectNow(3'd1, 0, "R1 cfg reset");
    expectNow(3'd4, 0, "R1 count reset");
    expectNow(3'd2, 255, "R1 reload reset");
    expectNow(3'd5, 0, "R1 status reset");

    // writes while disabled are discarded
    wr(3'd2, 16);
    wr(3'd3, 5);
    repeat (4) @(negedge clk);
    expectNow(3'd2, 255, "R8 reload write dropped");
    expectNow(3'd5, 0, "R8 no flag when disabled");

    // start in the same write as enable does not run
    wr(3'd0, 3);
    expectNow(3'd0, 1, "R11 start with enable ignored");
    pulseA();
    expectNow(3'd4, 0, "R11 not running holds count");
    wr(3'd0, 3);
    expectNow(3'd0, 3, "R11 running after start");

    // synchronizer latency
    @(negedge clk); encA = 1'b1;
    @(negedge clk);
    @(negedge clk);
    expectNow(3'd4, 0, "R12 no change after two edges");
    @(negedge clk);
    expectNow(3'd4, 1, "R12 change at third edge");
    setAB(0, 0);
    expectNow(3'd4, 1, "R2 falling ignored with rising polarity");
    pulseA(); pulseA();
    expectNow(3'd4, 3, "R2 plain rising count");
    setAB(0, 1); setAB(0, 0);
    expectNow(3'd4, 3, "R2 input B ignored in plain mode");

    // cfg locked while enabled
    wr(3'd1, 5);
    expectNow(3'd1, 0, "R7 cfg write ignored while enabled");
    pulseA();
    expectNow(3'd4, 4, "R7 still plain mode");

    // reload acknowledge latency
    wr(3'd2, 5);
    @(negedge clk);
    @(negedge clk);
    expectNow(3'd5, 0, "R9 flag not set after two edges");
    @(negedge clk);
    expectNow(3'd5, 1, "R9 reload flag set at third edge");
    expectNow(3'd2, 5, "R9 reload accepted");
    repeat (6) @(negedge clk);
    expectNow(3'd5, 1, "R9 flag sticky");

    pulseA();
    expectNow(3'd4, 5, "R5 count reaches reload");
    pulseA();
    expectNow(3'd4, 0, "R5 wrap to zero");

    wr(3'd6, 1);
    expectNow(3'd5, 0, "R10 clear reload flag");
    wr(3'd3, 34);
    repeat (3) @(negedge clk);
    expectNow(3'd5, 2, "R9 compare flag set");
    expectNow(3'd3, 34, "R9 compare accepted");
    wr(3'd6, 2);
    expectNow(3'd5, 0, "R10 clear compare flag");

    // disabling stops counting
    pulseA();
    expectNow(3'd4, 1, "R11 count before disable");
    wr(3'd0, 0);
    expectNow(3'd0, 0, "R11 disable clears running");
    pulseA();
    expectNow(3'd4, 1, "R11 disabled holds count");

    // quadrature, both edges
    wr(3'd1, 5);
    expectNow(3'd1, 5, "R7 cfg write taken while disabled");
    wr(3'd0, 1);
    expectNow(3'd4, 0, "R11 enable clears count");
    wr(3'd2, 200);
    wr(3'd0, 3);
    fwdCycle();
    expectNow(3'd4, 4, "R4 forward x4");
    revCycle();
    expectNow(3'd4, 0, "R4 reverse x4");
    setAB(0, 1);
    expectNow(3'd4, 200, "R6 wrap down to reload");
    setAB(0, 0);
    expectNow(3'd4, 0, "R5 wrap up from reload");

    // quadrature, rising only
    wr(3'd0, 0);
    wr(3'd1, 1);
    wr(3'd0, 1);
    wr(3'd0, 3);
    fwdCycle();
    expectNow(3'd4, 2, "R3 rising forward");
    revCycle();
    expectNow(3'd4, 0, "R3 rising reverse");

    // quadrature, falling only
    wr(3'd0, 0);
    wr(3'd1, 3);
    wr(3'd0, 1);
    wr(3'd0, 3);
    setAB(1, 0); setAB(1, 1);
    expectNow(3'd4, 0, "R3 falling ignores rising edges");
    setAB(0, 1); setAB(0, 0);
    expectNow(3'd4, 2, "R3 falling forward");

    // plain mode, both edges
    wr(3'd0, 0);
    wr(3'd1, 4);
    wr(3'd0, 1);
    wr(3'd0, 3);
    pulseA();
    expectNow(3'd4, 2, "R2 plain both edges");

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule